// File: doc/BRIEF.md
# Serial EEPROM Reload/Store Controller

This block moves 16-bit words between a small serial EEPROM and a bank of internal configuration registers. A reload fills registers from the EEPROM and a store copies registers into it. A select bit in the control register picks the target. With select clear, the target is the configuration group: a configuration word, a base word and several individual-address words. With select set, the target is one general-purpose word. Hardware reset starts a reload of the configuration group on its own, so the registers come up with their stored values.

The CPU reaches the block through a plain register port. Address 0 is the control register. Address 1 holds the configuration word, address 2 the base word, addresses 3 to 2+IA_WORDS the individual-address words, and the last address the general-purpose word. Register address k maps to EEPROM word k-1. While a transfer runs, the block shields its registers: every CPU write is dropped, and reads of the control register only report that the block is busy. The EEPROM side is a four-wire serial link (select, clock, data out, data in). Its clock is a divided copy of the system clock.

Top module: `eeprom_xfer_ctrl`

## Requirements
- R1: After reset the block is busy and reloads EEPROM words 0 to 1+IA_WORDS into register addresses 1 to 2+IA_WORDS. The select bit resets to 0 and the general-purpose register stays 0.
- R2: With select (control bit 2) at 1, a reload or store transfers only the general-purpose register (EEPROM word 2+IA_WORDS). No other register or EEPROM word changes.
- R3: With select at 0, a store writes only register addresses 1 and 2 into EEPROM words 0 and 1. A reload loads every word of the configuration group.
- R4: A CPU write to address 0 while idle with bit 0 (reload) or bit 1 (store) set starts an operation. The block is busy from the next cycle, and the select value written in that same write applies to the operation.
- R5: When the operation completes, bits 0 and 1 read back as 0. The select bit keeps its written value.
- R6: While busy, address 0 reads as 0x0003: bits 0 and 1 are high and all other bits are 0.
- R7: While busy, CPU writes to any address have no effect. Reads of register addresses 1 and up return 0.
- R8: A control write with both bit 0 and bit 1 set performs a reload.
- R9: The serial clock stays high for exactly CLK_DIV system cycles. It is only high while chip select is high, and data out only changes while the clock is low. Each frame is sent MSB first as: start bit 1, opcode (10 = read, 01 = write), an EE_AW-bit word address, then 16 data bits.
- R10: After each write frame, chip select drops and then rises again. The next frame begins only once the EEPROM data line reads high (ready).
- R11: No operation keeps the block busy for MAX_BUSY_CYC cycles or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts an automatic reload |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | $clog2(IA_WORDS+4) | CPU register address (0 = control) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data for cpu_addr (combinational) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data / ready from the EEPROM |

## Verification
The bench builds the block with CLK_DIV = 3, EE_AW = 6 and IA_WORDS = 3, which gives six register words and a 64-word behavioural EEPROM. The divider value is odd and not a power of two, so the bench can check that each clock high phase lasts exactly three cycles. Six words are enough to tell the reload group apart from the store group, and to show that the general-purpose word sits outside both. The EEPROM model stays busy for 40 cycles after each write, which makes the ready wait between stored words visible.

// File: rtl/eex_pkg.sv
package eex_pkg;
  localparam int WORD_W     = 16;
  localparam int CTL_RELOAD = 0;
  localparam int CTL_STORE  = 1;
  localparam int CTL_SEL    = 2;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  typedef enum logic [1:0] {Q_IDLE, Q_ISSUE, Q_WAIT} seq_state_t;
  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL, S_DONE} ser_state_t;
endpackage

// File: rtl/eex_sclk_gen.sv
module eex_sclk_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);

  logic [CNTW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eex_serial.sv
module eex_serial
  import eex_pkg::*;
#(
  parameter int AW  = 6,
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_op,
  input  logic [AW-1:0]     word_addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int FW = 3 + AW + WORD_W;
  localparam int CW = $clog2(FW + 1);

  ser_state_t    st;
  logic [FW-1:0] sr;
  logic [CW-1:0] left;
  logic          is_wr;
  logic          run;
  logic          tick;

  assign run  = (st == S_SHIFT) || (st == S_GAP) || (st == S_POLL);
  assign done = (st == S_DONE);

  eex_sclk_gen #(.DIV(DIV)) u_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sr    <= '0;
      left  <= '0;
      is_wr <= 1'b0;
      rdata <= '0;
      ee_cs <= 1'b0;
      ee_sk <= 1'b0;
      ee_di <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sr    <= {1'b1, (wr_op ? OP_WRITE : OP_READ), word_addr,
                    (wr_op ? wdata : {WORD_W{1'b0}})};
          ee_di <= 1'b1;
          ee_cs <= 1'b1;
          is_wr <= wr_op;
          left  <= CW'(FW);
          st    <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
            rdata <= {rdata[WORD_W-2:0], ee_do};
          end else begin
            ee_sk <= 1'b0;
            if (left == CW'(1)) begin
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
              st    <= is_wr ? S_GAP : S_DONE;
            end else begin
              left  <= left - 1'b1;
              sr    <= {sr[FW-2:0], 1'b0};
              ee_di <= sr[FW-2];
            end
          end
        end
        S_GAP: if (tick) begin
          ee_cs <= 1'b1;
          st    <= S_POLL;
        end
        S_POLL: if (tick && ee_do) begin
          ee_cs <= 1'b0;
          st    <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eex_regfile.sv
module eex_regfile
  import eex_pkg::*;
#(
  parameter int NW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_we,
  input  logic [$clog2(NW)-1:0] cpu_idx,
  input  logic [WORD_W-1:0]    cpu_d,
  input  logic                 ld_we,
  input  logic [$clog2(NW)-1:0] ld_idx,
  input  logic [WORD_W-1:0]    ld_d,
  output logic [NW*WORD_W-1:0] q_flat
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q_flat[g*WORD_W +: WORD_W] <= '0;
      else if (ld_we && (int'(ld_idx) == g))
        q_flat[g*WORD_W +: WORD_W] <= ld_d;
      else if (cpu_we && (int'(cpu_idx) == g))
        q_flat[g*WORD_W +: WORD_W] <= cpu_d;
    end
  end
endmodule

// File: rtl/eeprom_xfer_ctrl.sv
module eeprom_xfer_ctrl
  import eex_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int EE_AW        = 6,
  parameter int IA_WORDS     = 3,
  parameter int MAX_BUSY_CYC = 75000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_we,
  input  logic [$clog2(IA_WORDS+4)-1:0] cpu_addr,
  input  logic [WORD_W-1:0]             cpu_wdata,
  output logic [WORD_W-1:0]             cpu_rdata,
  output logic                          ee_cs,
  output logic                          ee_sk,
  output logic                          ee_di,
  input  logic                          ee_do
);
  localparam int NW      = IA_WORDS + 3;
  localparam int CAW     = $clog2(NW + 1);
  localparam int WIW     = $clog2(NW);
  localparam logic [WIW-1:0] GP_IDX     = WIW'(NW - 1);
  localparam logic [WIW-1:0] GRP_RL_END = WIW'(IA_WORDS + 1);
  localparam logic [WIW-1:0] GRP_ST_END = WIW'(1);

  seq_state_t          q;
  logic                sel;
  logic                op_store;
  logic [WIW-1:0]      cur;
  logic [WIW-1:0]      last;
  logic                busy;
  logic                sh_done;
  logic [WORD_W-1:0]   sh_rdata;
  logic                seq_wr;
  logic                cpu_reg_wr;
  logic                addr_is_reg;
  logic [WIW-1:0]      cpu_idx;
  logic [NW*WORD_W-1:0] rf_flat;
  logic                req_rl;
  logic                req_st;
  logic                req_sel;

  assign busy        = (q != Q_IDLE);
  assign addr_is_reg = (cpu_addr != '0) && (int'(cpu_addr) <= NW);
  assign cpu_idx     = WIW'(cpu_addr - 1'b1);
  assign cpu_reg_wr  = cpu_we && !busy && addr_is_reg;
  assign seq_wr      = (q == Q_WAIT) && sh_done && !op_store;
  assign req_rl      = cpu_wdata[CTL_RELOAD];
  assign req_st      = cpu_wdata[CTL_STORE];
  assign req_sel     = cpu_wdata[CTL_SEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= Q_ISSUE;
      sel      <= 1'b0;
      op_store <= 1'b0;
      cur      <= '0;
      last     <= GRP_RL_END;
    end else begin
      case (q)
        Q_IDLE: if (cpu_we && (cpu_addr == '0)) begin
          sel <= req_sel;
          if (req_rl || req_st) begin
            op_store <= !req_rl;
            cur      <= req_sel ? GP_IDX : '0;
            last     <= req_sel ? GP_IDX : (req_rl ? GRP_RL_END : GRP_ST_END);
            q        <= Q_ISSUE;
          end
        end
        Q_ISSUE: q <= Q_WAIT;
        Q_WAIT: if (sh_done) begin
          if (cur == last) q <= Q_IDLE;
          else begin
            cur <= cur + 1'b1;
            q   <= Q_ISSUE;
          end
        end
        default: q <= Q_IDLE;
      endcase
    end
  end

  eex_serial #(.AW(EE_AW), .DIV(CLK_DIV)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (q == Q_ISSUE),
    .wr_op    (op_store),
    .word_addr(EE_AW'(cur)),
    .wdata    (rf_flat[cur*WORD_W +: WORD_W]),
    .done     (sh_done),
    .rdata    (sh_rdata),
    .ee_cs    (ee_cs),
    .ee_sk    (ee_sk),
    .ee_di    (ee_di),
    .ee_do    (ee_do)
  );

  eex_regfile #(.NW(NW)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .cpu_we (cpu_reg_wr),
    .cpu_idx(cpu_idx),
    .cpu_d  (cpu_wdata),
    .ld_we  (seq_wr),
    .ld_idx (cur),
    .ld_d   (sh_rdata),
    .q_flat (rf_flat)
  );

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == '0) begin
      if (busy) begin
        cpu_rdata[CTL_RELOAD] = 1'b1;
        cpu_rdata[CTL_STORE]  = 1'b1;
      end else begin
        cpu_rdata[CTL_SEL] = sel;
      end
    end else if (!busy && addr_is_reg) begin
      cpu_rdata = rf_flat[cpu_idx*WORD_W +: WORD_W];
    end
  end

  if (CAW < 1) begin : g_bad_cfg
    initial $error("address width too small");
  end
endmodule

// File: rtl/eex_ctrl_chk.sv
module eex_ctrl_chk #(
  parameter int DIV      = 4,
  parameter int CAW      = 3,
  parameter int FLAT_W   = 96,
  parameter int MAX_BUSY = 75000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [CAW-1:0]    cpu_addr,
  input logic [15:0]       cpu_wdata,
  input logic [15:0]       cpu_rdata,
  input logic              busy,
  input logic              seq_wr,
  input logic [FLAT_W-1:0] rf_flat,
  input logic              ee_cs,
  input logic              ee_sk,
  input logic              ee_di
);
  int unsigned hi_run;
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run   <= 0;
      busy_run <= 0;
    end else begin
      hi_run   <= ee_sk ? hi_run + 1 : 0;
      busy_run <= busy ? busy_run + 1 : 0;
    end
  end

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cpu_we && (cpu_addr == '0) && (cpu_wdata[0] || cpu_wdata[1])) |=> busy);

  // R6
  busy_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cpu_addr == '0)) |-> (cpu_rdata == 16'h0003));

  // R7
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cpu_we && !seq_wr) |=> $stable(rf_flat));

  // R9
  sk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= DIV);

  // R9
  sk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  // R9
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  // R11
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run < MAX_BUSY);
endmodule

bind eeprom_xfer_ctrl eex_ctrl_chk #(
  .DIV     (CLK_DIV),
  .CAW     ($clog2(IA_WORDS+4)),
  .FLAT_W  ((IA_WORDS+3)*16),
  .MAX_BUSY(MAX_BUSY_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_we   (cpu_we),
  .cpu_addr (cpu_addr),
  .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata),
  .busy     (busy),
  .seq_wr   (seq_wr),
  .rf_flat  (rf_flat),
  .ee_cs    (ee_cs),
  .ee_sk    (ee_sk),
  .ee_di    (ee_di)
);

// File: tb/eeprom_xfer_ctrl_bench.sv
module eeprom_xfer_ctrl_bench;
  localparam int DIV   = 3;
  localparam int AW    = 6;
  localparam int IA    = 3;
  localparam int NW    = IA + 3;
  localparam int CAW   = $clog2(IA + 4);
  localparam int MAXB  = 75000;
  localparam int BUSYW = 40;
  localparam int HB    = 3 + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [CAW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic ee_cs, ee_sk, ee_di, ee_do;

  always #5 clk = ~clk;

  eeprom_xfer_ctrl #(.CLK_DIV(DIV), .EE_AW(AW), .IA_WORDS(IA), .MAX_BUSY_CYC(MAXB)) u_eeprom_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // behavioural EEPROM responder
  logic [15:0] mem [1<<AW];
  int cyc = 0, busy_until = 0, bitn = 0, rdcnt = 0;
  int rframes = 0, wframes = 0, busy_viol = 0, di_viol = 0;
  int hi_len = 0, hi_min = 1000, hi_max = 0;
  logic pcs = 1'b0, psk = 1'b0, rdm = 1'b0, wrm = 1'b0, dout = 1'b0, di_hi = 1'b0;
  logic [HB-1:0] hdr = '0;
  logic [15:0] dsh = '0, rdword = '0;
  logic [AW-1:0] waddr = '0;

  assign ee_do = rdm ? dout : (cyc >= busy_until);

  always @(negedge clk) begin
    cyc++;
    if (ee_cs && !pcs) begin bitn = 0; hdr = '0; rdm = 1'b0; wrm = 1'b0; rdcnt = 0; end
    if (!ee_cs && pcs) begin
      if (wrm && bitn == HB + 16) begin mem[waddr] = dsh; busy_until = cyc + BUSYW; end
      wrm = 1'b0; rdm = 1'b0;
    end
    if (ee_sk && !psk && ee_cs) begin
      di_hi = ee_di;
      if (bitn < HB) begin
        if (bitn == 0 && cyc < busy_until) busy_viol++;
        hdr = {hdr[HB-2:0], ee_di};
        bitn++;
        if (bitn == HB) begin
          waddr = hdr[AW-1:0];
          if (hdr[AW+1:AW] == 2'b10) begin rdm = 1'b1; rdword = mem[hdr[AW-1:0]]; rframes++; end
          if (hdr[AW+1:AW] == 2'b01) begin wrm = 1'b1; wframes++; end
        end
      end else if (wrm) begin
        dsh = {dsh[14:0], ee_di};
        bitn++;
      end
    end
    if (ee_sk && psk && ee_di != di_hi) di_viol++;
    if (!ee_sk && psk && rdm && rdcnt < 16) begin dout = rdword[15-rdcnt]; rdcnt++; end
    if (ee_sk) hi_len++;
    else if (psk) begin
      if (hi_len < hi_min) hi_min = hi_len;
      if (hi_len > hi_max) hi_max = hi_len;
      hi_len = 0;
    end
    pcs = ee_cs; psk = ee_sk;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input int a, input logic [15:0] d);
    @(negedge clk); cpu_we = 1'b1; cpu_addr = CAW'(a); cpu_wdata = d;
    @(negedge clk); cpu_we = 1'b0;
  endtask

  task automatic cpu_read(input int a, output logic [15:0] d);
    @(negedge clk); cpu_addr = CAW'(a); #1 d = cpu_rdata;
  endtask

  task automatic wait_idle(output int cycles);
    logic [15:0] d;
    cycles = 0;
    for (int i = 0; i < 50000; i++) begin
      cpu_read(0, d);
      if (d[1:0] == 2'b00) break;
      cycles++;
    end
  endtask

  task automatic t_reset_reload();
    logic [15:0] d; int c;
    cpu_read(0, d);
    chk(d == 16'h0003, "R1 busy after reset", d, 16'h0003);
    wait_idle(c);
    chk(c < MAXB, "R11 reset reload bound", c, MAXB);
    cpu_read(0, d);
    chk(d == 16'h0000, "R5 bits cleared, select 0", d, 16'h0000);
    for (int k = 1; k <= IA + 2; k++) begin
      cpu_read(k, d);
      chk(d == mem[k-1], "R1 reloaded word", d, mem[k-1]);
    end
    cpu_read(NW, d);
    chk(d == 16'h0000, "R1 gp untouched", d, 16'h0000);
    chk(rframes == IA + 2, "R3 reload frame count", rframes, IA + 2);
  endtask

  task automatic t_busy_lock();
    logic [15:0] d; int c, r0, w0;
    mem[0] = 16'h3C3C;
    r0 = rframes; w0 = wframes;
    cpu_write(0, 16'h0001);
    cpu_read(0, d);
    chk(d == 16'h0003, "R6 busy readback", d, 16'h0003);
    cpu_read(1, d);
    chk(d == 16'h0000, "R7 register read hidden while busy", d, 16'h0000);
    cpu_write(1, 16'hDEAD);
    cpu_write(0, 16'h0006);
    wait_idle(c);
    cpu_read(1, d);
    chk(d == 16'h3C3C, "R7 write during busy dropped", d, 16'h3C3C);
    cpu_read(0, d);
    chk(d == 16'h0000, "R7 control write during busy dropped", d, 16'h0000);
    chk(wframes == w0 && rframes == r0 + IA + 2, "R7 no extra operation", wframes - w0, 0);
  endtask

  task automatic t_store_group();
    logic [15:0] d, keep; int c, w0;
    keep = mem[2]; w0 = wframes;
    cpu_write(1, 16'h1234);
    cpu_write(2, 16'h5678);
    cpu_write(3, 16'h9ABC);
    cpu_write(0, 16'h0002);
    cpu_read(0, d);
    chk(d == 16'h0003, "R4 store starts", d, 16'h0003);
    wait_idle(c);
    chk(mem[0] == 16'h1234, "R3 config stored", mem[0], 16'h1234);
    chk(mem[1] == 16'h5678, "R3 base stored", mem[1], 16'h5678);
    chk(mem[2] == keep, "R3 address word not stored", mem[2], keep);
    chk(wframes == w0 + 2, "R3 two write frames", wframes - w0, 2);
    chk(busy_viol == 0, "R10 frame started while EEPROM busy", busy_viol, 0);
    cpu_read(0, d);
    chk(d == 16'h0000, "R5 store bit cleared", d, 16'h0000);
  endtask

  task automatic t_gp();
    logic [15:0] d, c0; int c;
    c0 = mem[0];
    cpu_write(NW, 16'hBEEF);
    cpu_write(0, 16'h0006);
    wait_idle(c);
    chk(mem[NW-1] == 16'hBEEF, "R2 gp stored", mem[NW-1], 16'hBEEF);
    chk(mem[0] == c0, "R2 config word untouched", mem[0], c0);
    cpu_read(0, d);
    chk(d == 16'h0004, "R5 select retained", d, 16'h0004);
    mem[NW-1] = 16'h4242;
    mem[0] = 16'h0F0F;
    cpu_write(NW, 16'h0000);
    cpu_write(0, 16'h0005);
    wait_idle(c);
    cpu_read(NW, d);
    chk(d == 16'h4242, "R2 gp reloaded", d, 16'h4242);
    cpu_read(1, d);
    chk(d == 16'h1234, "R2 config register untouched", d, 16'h1234);
    chk(busy_viol == 0, "R10 ready wait after gp store", busy_viol, 0);
  endtask

  task automatic t_priority();
    logic [15:0] d; int c, w0;
    w0 = wframes;
    cpu_write(1, 16'h1111);
    mem[0] = 16'h7777;
    cpu_write(0, 16'h0003);
    wait_idle(c);
    cpu_read(1, d);
    chk(d == 16'h7777, "R8 reload wins", d, 16'h7777);
    chk(mem[0] == 16'h7777 && wframes == w0, "R8 no store", mem[0], 16'h7777);
  endtask

  task automatic t_serial_timing();
    chk(hi_min == DIV && hi_max == DIV, "R9 clock high width", hi_max, DIV);
    chk(di_viol == 0, "R9 data held while clock high", di_viol, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'hA000 ^ 16'(i * 16'h0137);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_reload();
    t_busy_lock();
    t_store_group();
    t_gp();
    t_priority();
    t_serial_timing();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule